// File: doc/BRIEF.md
# Status Word System-Mask Swap Unit

This block holds a processor status word. It carries out the instruction that replaces the system-mask portion of that word. When the swap strobe is raised, the bits of the new-mask operand that lie inside the system-mask field replace the same bits of the status word, and every bit outside the field is kept. On the next cycle the block returns the field contents as they were before the swap.

One bit inside the field, the interruption-state-collection bit (Q), is protected. If a swap would set Q while Q is currently clear, the swap is refused. In that case the block raises a one-cycle illegal-instruction trap pulse, and the status word and the returned-mask output both keep their values. Reset loads a parameterised status value in which Q is clear. The field position, the field width and the position of Q are all parameters.

Top module: `smx_swap_unit`

## Requirements
- R1: Synchronous active-high reset sets status_o to RESET_WORD (default 32'h0004_0005, with Q clear), old_mask_o to zero and trap_o to 0.
- R2: An accepted swap (swap_i high at a rising edge, no trap) makes status_o, from that edge on, equal to the old word with bits FIELD_LO..FIELD_LO+FIELD_W-1 taken from new_mask_i. With the defaults these are bits 7..0. Bits of new_mask_i outside the field have no effect, and status bits outside the field are preserved.
- R3: After an accepted swap, old_mask_o holds the status word as it stood before that edge, ANDed with the field mask (default 32'h0000_00FF). Bits outside the field read as zero.
- R4: A swap with new_mask_i[Q_POS] = 1 (default bit 3) while status_o[Q_POS] = 0 raises trap_o for exactly the one cycle that follows that edge.
- R5: A trapped swap leaves status_o and old_mask_o unchanged.
- R6: With swap_i low, status_o, old_mask_o and trap_o do not change, whatever new_mask_i is. In this case trap_o stays 0.
- R7: Swaps on consecutive cycles are each applied in order. Each one returns the field as left by the swap before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| swap_i | input | 1 | Swap strobe, one swap per cycle it is high |
| new_mask_i | input | W | New system-mask value (field bits used) |
| old_mask_o | output | W | Field contents before the last accepted swap |
| status_o | output | W | Current status word |
| trap_o | output | 1 | Illegal-instruction trap pulse |

## Verification
A swap request and the Q-protection trap fall in the same cycle whenever a swap operand sets Q while Q is clear. The check then has to decide which of the two wins. The bench provokes this with an operand that has only the Q bit set, issued right after a legal swap has changed the field. It then requires trap_o high for one cycle, while both status_o and old_mask_o still show the values the legal swap left behind. Back-to-back legal swaps are also issued, to confirm that each returned mask reflects the swap just before it.

// File: rtl/smx_pkg.sv
package smx_pkg;

    typedef struct packed {
        logic accept;
        logic trap;
    } swap_verdict_t;

    function automatic logic [63:0] span_mask(input int lo, input int width);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < 64; i++) begin
            if (i >= lo && i < lo + width) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/smx_guard.sv
module smx_guard
    import smx_pkg::*;
(
    input  logic          swap_i,
    input  logic          new_q_i,
    input  logic          cur_q_i,
    output swap_verdict_t verdict_o
);
    logic illegal;

    always_comb begin
        illegal          = new_q_i & ~cur_q_i;
        verdict_o.trap   = swap_i & illegal;
        verdict_o.accept = swap_i & ~illegal;
    end
endmodule

// File: rtl/smx_merge.sv
module smx_merge #(
    parameter int W = 32,
    parameter logic [W-1:0] FIELD = '0
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] new_i,
    output logic [W-1:0] next_o,
    output logic [W-1:0] field_o
);
    always_comb begin
        next_o  = (cur_i & ~FIELD) | (new_i & FIELD);
        field_o = cur_i & FIELD;
    end
endmodule

// File: rtl/smx_swap_unit.sv
module smx_swap_unit
    import smx_pkg::*;
#(
    parameter int W = 32,
    parameter int FIELD_LO = 0,
    parameter int FIELD_W = 8,
    parameter int Q_POS = 3,
    parameter logic [W-1:0] RESET_WORD = 32'h0004_0005
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         swap_i,
    input  logic [W-1:0] new_mask_i,
    output logic [W-1:0] old_mask_o,
    output logic [W-1:0] status_o,
    output logic         trap_o
);
    localparam logic [W-1:0] FIELD = W'(span_mask(FIELD_LO, FIELD_W));

    initial begin
        if (Q_POS < FIELD_LO || Q_POS >= FIELD_LO + FIELD_W)
            $error("Q_POS must lie inside the system-mask field");
        if (RESET_WORD[Q_POS] != 1'b0)
            $error("RESET_WORD must have Q clear");
    end

    logic [W-1:0]  status_q, old_q, next_word, cur_field;
    logic          trap_q;
    swap_verdict_t verdict;

    smx_guard u_guard (
        .swap_i   (swap_i),
        .new_q_i  (new_mask_i[Q_POS]),
        .cur_q_i  (status_q[Q_POS]),
        .verdict_o(verdict)
    );

    smx_merge #(.W(W), .FIELD(FIELD)) u_merge (
        .cur_i  (status_q),
        .new_i  (new_mask_i),
        .next_o (next_word),
        .field_o(cur_field)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= RESET_WORD;
            old_q    <= '0;
            trap_q   <= 1'b0;
        end else begin
            trap_q <= verdict.trap;
            if (verdict.accept) begin
                status_q <= next_word;
                old_q    <= cur_field;
            end
        end
    end

    assign status_o   = status_q;
    assign old_mask_o = old_q;
    assign trap_o     = trap_q;

    AST_OUTSIDE_KEPT: assert property (@(posedge clk) disable iff (rst)
        $stable(status_q & ~FIELD)); // R2
    AST_OLD_IN_FIELD: assert property (@(posedge clk) disable iff (rst)
        (old_q & ~FIELD) == '0); // R3
    AST_TRAP_FROM_STROBE: assert property (@(posedge clk) disable iff (rst)
        trap_q |-> $past(swap_i)); // R4
    AST_Q_NEVER_RISES: assert property (@(posedge clk) disable iff (rst)
        !$rose(status_q[Q_POS])); // R4
    AST_TRAP_FREEZES: assert property (@(posedge clk) disable iff (rst)
        trap_q |-> ($stable(status_q) && $stable(old_q))); // R5
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !swap_i |=> ($stable(status_q) && !trap_q)); // R6
endmodule

// File: tb/smx_swap_unit_tb.sv
module smx_swap_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] FIELD = 32'h0000_00FF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        swap_i = 1'b0;
    logic [31:0] new_mask_i = '0;
    logic [31:0] old_mask_o, status_o;
    logic        trap_o;

    int total = 0;
    int bad = 0;
    logic [31:0] exp_status, exp_old;

    always #(CLK_PERIOD/2) clk = ~clk;

    smx_swap_unit u_dut (
        .clk(clk), .rst(rst), .swap_i(swap_i), .new_mask_i(new_mask_i),
        .old_mask_o(old_mask_o), .status_o(status_o), .trap_o(trap_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic legal_swap(input logic [31:0] nm);
        @(negedge clk);
        swap_i = 1'b1; new_mask_i = nm;
        @(negedge clk);
        swap_i = 1'b0;
        exp_old    = exp_status & FIELD;
        exp_status = (exp_status & ~FIELD) | (nm & FIELD);
        check("R2 status", status_o, exp_status);
        check("R3 old mask", old_mask_o, exp_old);
        check("R4 no trap", {31'b0, trap_o}, 32'h0);
    endtask

    task automatic test_reset;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_status = 32'h0004_0005;
        exp_old = '0;
        check("R1 status", status_o, exp_status);
        check("R1 old mask", old_mask_o, 32'h0);
        check("R1 trap", {31'b0, trap_o}, 32'h0);
    endtask

    task automatic test_trap;
        legal_swap(32'h0000_0041);
        @(negedge clk);
        swap_i = 1'b1; new_mask_i = 32'h0000_0008;
        @(negedge clk);
        swap_i = 1'b0; new_mask_i = 32'h0;
        check("R4 trap pulse", {31'b0, trap_o}, 32'h1);
        check("R5 status held", status_o, exp_status);
        check("R5 old held", old_mask_o, exp_old);
        @(negedge clk);
        check("R4 single cycle", {31'b0, trap_o}, 32'h0);
    endtask

    task automatic test_idle;
        @(negedge clk);
        new_mask_i = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R6 status", status_o, exp_status);
        check("R6 old", old_mask_o, exp_old);
        check("R6 trap", {31'b0, trap_o}, 32'h0);
    endtask

    task automatic test_back_to_back;
        @(negedge clk);
        swap_i = 1'b1; new_mask_i = 32'hAB00_0012;
        @(negedge clk);
        exp_old = exp_status & FIELD;
        exp_status = (exp_status & ~FIELD) | 32'h12;
        check("R7 first status", status_o, exp_status);
        check("R7 first old", old_mask_o, exp_old);
        new_mask_i = 32'h0000_0034;
        @(negedge clk);
        swap_i = 1'b0;
        check("R7 second status", status_o, 32'h0004_0034);
        check("R7 second old", old_mask_o, 32'h0000_0012);
        exp_status = 32'h0004_0034; exp_old = 32'h12;
    endtask

    initial begin
        test_reset();
        legal_swap(32'hFFFF_00F0);
        check("R2 outside kept", status_o, 32'h0004_00F0);
        test_trap();
        test_idle();
        test_back_to_back();
        legal_swap(32'h0000_0000);
        check("R2 cleared field", status_o, 32'h0004_0000);
        check("R3 returned prior", old_mask_o, 32'h0000_0034);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule